// File: doc/BRIEF.md
# Nested Prioritized Interrupt Controller

This block gathers interrupt requests from peripheral lines, from a bank of external pins and from a dedicated top-level pin, and picks one to hand to the processor. It also decides whether that request may break into the code that is running now. Each maskable vector has a two-bit software level. A request can preempt only code that runs at a strictly lower level. When several candidates share the top level, the lowest vector index wins. A software-reset source and a trap source sit above all of this. Neither can be masked, and each lifts execution to the top level.

The external pins are edge-detected one by one. They are then folded in contiguous runs onto a small number of shared vectors, so a single grant services the whole group. The controller holds the execution level itself. On each grant it pushes the level being left onto a small stack, and it pops that level back when the return strobe arrives. A grant appears as a one-cycle take pulse carrying the registered vector index and the new level. No further grant is made until the processor acknowledges.

Top module: `nest_irq_ctrl`

## Requirements
- R1: A source is latched as pending on a rising edge of its input only. An input held high does not latch again, and a source input already high while reset is asserted latches nothing. A pending vector is cleared in the cycle it is granted.
- R2: Vector map: 0 is software reset, 1 is trap, 2 is the top-level pin, and 3 to 3+NGRP-1 are the pin groups. Peripheral line i is vector 3+NGRP+i. Pin p folds onto group p/ceil(NPINS/NGRP), so pins of one group raised together give one grant.
- R3: The level of maskable vector v sits at prio_cfg bits [2(v-2)+1 : 2(v-2)]. 2'b00 disables the vector, and 2'b01 to 2'b11 are levels 1 to 3, with 3 the highest.
- R4: A maskable vector is granted only if its level is strictly greater than the current exec_lvl.
- R5: Among eligible maskable vectors the highest level wins, and equal levels go to the lowest index.
- R6: Reset and trap ignore gmask and levels and beat every maskable vector, with reset beating trap. Their grant sets exec_lvl to 3.
- R7: While gmask is 1 no maskable vector is granted. Its pending state is kept and it is granted once gmask is 0 and the level allows.
- R8: A grant raises take for exactly one cycle. In that same cycle vec_idx and exec_lvl show the granted vector and its level, and both hold until changed.
- R9: After a take, no further take occurs until ack has been seen high in a cycle after the take began.
- R10: iret pops the stack and restores the saved level. An iret with an empty stack leaves exec_lvl unchanged, and no grant is made in a cycle where iret is high.
- R11: The level stack holds DEPTH entries. When it is full, maskable and trap grants wait. A reset grant empties the stack.
- R12: After reset, take is 0, vec_idx is 0, exec_lvl is 0 and nothing is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | NPINS | External interrupt pins, folded onto group vectors |
| tli_pin | input | 1 | Top-level interrupt pin, vector 2 |
| periph_req | input | NVEC-3-NGRP | Peripheral request lines |
| trap_req | input | 1 | Trap source, non-maskable |
| swrst_req | input | 1 | Software reset source, non-maskable |
| prio_cfg | input | 2*(NVEC-2) | Two-bit level per maskable vector |
| gmask | input | 1 | Global mask of maskable grants |
| ack | input | 1 | Processor acknowledge of a take |
| iret | input | 1 | Return-from-interrupt strobe |
| take | output | 1 | One-cycle grant pulse |
| vec_idx | output | $clog2(NVEC) | Granted vector index |
| exec_lvl | output | 2 | Current execution level |

## Verification
The bench builds the controller with its defaults: 32 vectors, 27 pins in 6 groups and a stack of depth 4. With these values the groups hold five pins each and the last group is partly filled, so a pin at the group boundary and the last pin (26, vector 8) both land on known vectors. Depth 4 equals three nested maskable levels plus one trap. Four nested traps therefore fill the stack, which puts the full-stack hold and the reset-clears-stack path within reach.

// File: rtl/irq_pkg.sv
package irq_pkg;

    typedef logic [1:0] lvl_t;

    localparam lvl_t LVL_OFF = 2'b00;
    localparam lvl_t LVL_TOP = 2'b11;

    localparam int VEC_SWRST = 0;
    localparam int VEC_TRAP  = 1;
    localparam int VEC_TLI   = 2;
    localparam int VEC_GRP0  = 3;

    typedef struct packed {
        logic hit;
        logic rst_win;
        lvl_t lvl;
    } pick_t;

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

endpackage

// File: rtl/irq_src_front.sv
module irq_src_front
    import irq_pkg::*;
#(
    parameter int NVEC  = 32,
    parameter int NPINS = 27,
    parameter int NGRP  = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NPINS-1:0]          ext_pin,
    input  logic                      tli_pin,
    input  logic [NVEC-4-NGRP:0]      periph_req,
    input  logic                      trap_req,
    input  logic                      swrst_req,
    output logic [NVEC-1:0]           set_vec
);
    localparam int NPER  = NVEC - VEC_GRP0 - NGRP;
    localparam int FIRST = VEC_GRP0 + NGRP;
    localparam int NRAW  = NPER + NPINS + 3;
    localparam int PPG   = ceil_div(NPINS, NGRP);

    logic [NRAW-1:0] raw, prev, rise;
    logic [NGRP-1:0] grp_rise;

    assign raw  = {periph_req, ext_pin, tli_pin, trap_req, swrst_req};
    assign rise = raw & ~prev;

    // previous sample follows inputs during reset too, so a level already high is no edge
    always_ff @(posedge clk) begin
        prev <= raw;
    end

    function automatic logic [NPINS-1:0] grp_mask(input int g);
        logic [NPINS-1:0] m;
        for (int p = 0; p < NPINS; p++) begin
            m[p] = ((p / PPG) == g);
        end
        return m;
    endfunction

    generate
        for (genvar g = 0; g < NGRP; g++) begin : g_fold
            localparam logic [NPINS-1:0] MASK = grp_mask(g);
            assign grp_rise[g] = |(rise[3 +: NPINS] & MASK);
        end
    endgenerate

    assign set_vec[VEC_SWRST]       = rise[0];
    assign set_vec[VEC_TRAP]        = rise[1];
    assign set_vec[VEC_TLI]         = rise[2];
    assign set_vec[VEC_GRP0 +: NGRP] = grp_rise;
    assign set_vec[FIRST +: NPER]   = rise[3 + NPINS +: NPER];

endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
    parameter int NVEC = 32,
    localparam int VW  = $clog2(NVEC)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NVEC-1:0] set_vec,
    input  logic            clr_en,
    input  logic [VW-1:0]   clr_idx,
    output logic [NVEC-1:0] pend
);
    generate
        for (genvar g = 0; g < NVEC; g++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst) begin
                    pend[g] <= 1'b0;
                end else if (set_vec[g]) begin
                    pend[g] <= 1'b1;
                end else if (clr_en && (clr_idx == VW'(g))) begin
                    pend[g] <= 1'b0;
                end
            end

            // R1: a granted vector with no fresh edge is no longer pending
            a_r1_clear_on_grant: assert property (@(posedge clk) disable iff (rst)
                (clr_en && clr_idx == VW'(g) && !set_vec[g]) |=> !pend[g]);
        end
    endgenerate

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int NVEC = 32,
    localparam int VW  = $clog2(NVEC)
) (
    input  logic [NVEC-1:0]     pend,
    input  logic [2*NVEC-5:0]   prio_cfg,
    input  lvl_t                cur_lvl,
    input  logic                gmask,
    output pick_t               pick,
    output logic [VW-1:0]       win_vec
);
    lvl_t lv [NVEC];

    generate
        for (genvar v = 2; v < NVEC; v++) begin : g_lv
            assign lv[v] = prio_cfg[2*(v-2) +: 2];
        end
    endgenerate
    assign lv[0] = LVL_TOP;
    assign lv[1] = LVL_TOP;

    always_comb begin
        pick    = '0;
        win_vec = '0;
        // descending scan with >= leaves the lowest index among the highest level
        for (int v = NVEC - 1; v >= 2; v--) begin
            if (pend[v] && !gmask && (lv[v] != LVL_OFF) && (lv[v] > cur_lvl)
                && (!pick.hit || (lv[v] >= pick.lvl))) begin
                pick.hit = 1'b1;
                pick.lvl = lv[v];
                win_vec  = VW'(v);
            end
        end
        if (pend[VEC_TRAP]) begin
            pick    = '{hit: 1'b1, rst_win: 1'b0, lvl: lv[VEC_TRAP]};
            win_vec = VW'(VEC_TRAP);
        end
        if (pend[VEC_SWRST]) begin
            pick    = '{hit: 1'b1, rst_win: 1'b1, lvl: lv[VEC_SWRST]};
            win_vec = VW'(VEC_SWRST);
        end
    end

endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
    import irq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int SW   = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic pop,
    input  logic clear,
    input  lvl_t push_lvl,
    output lvl_t top_lvl,
    output logic empty,
    output logic full
);
    lvl_t          mem [DEPTH];
    logic [SW-1:0] sp;
    logic [SW-1:0] sp_m1;

    assign empty   = (sp == '0);
    assign full    = (sp == SW'(DEPTH));
    assign sp_m1   = sp - SW'(1);
    assign top_lvl = empty ? LVL_OFF : mem[sp_m1[IW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= '0;
        end else if (clear) begin
            sp <= '0;
        end else if (push) begin
            mem[sp[IW-1:0]] <= push_lvl;
            sp              <= sp + SW'(1);
        end else if (pop) begin
            sp <= sp_m1;
        end
    end

    // R11: depth never exceeded and no push into a full stack
    a_r11_sp_bound: assert property (@(posedge clk) disable iff (rst)
        sp <= SW'(DEPTH));
    a_r11_no_push_full: assert property (@(posedge clk) disable iff (rst)
        full |-> !push);
    // R10: a pop is only requested when something is saved
    a_r10_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import irq_pkg::*;
#(
    parameter int NVEC  = 32,
    parameter int NPINS = 27,
    parameter int NGRP  = 6,
    parameter int DEPTH = 4,
    localparam int VW   = $clog2(NVEC),
    localparam int NPER = NVEC - VEC_GRP0 - NGRP
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NPINS-1:0]      ext_pin,
    input  logic                  tli_pin,
    input  logic [NPER-1:0]       periph_req,
    input  logic                  trap_req,
    input  logic                  swrst_req,
    input  logic [2*NVEC-5:0]     prio_cfg,
    input  logic                  gmask,
    input  logic                  ack,
    input  logic                  iret,
    output logic                  take,
    output logic [VW-1:0]         vec_idx,
    output logic [1:0]            exec_lvl
);
    logic [NVEC-1:0] set_vec, pend;
    pick_t           pick;
    logic [VW-1:0]   win_vec;
    logic            busy, can_go;
    lvl_t            stk_top;
    logic            stk_empty, stk_full;

    irq_src_front #(.NVEC(NVEC), .NPINS(NPINS), .NGRP(NGRP)) u_front (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .tli_pin(tli_pin),
        .periph_req(periph_req), .trap_req(trap_req), .swrst_req(swrst_req),
        .set_vec(set_vec)
    );

    irq_pending #(.NVEC(NVEC)) u_pend (
        .clk(clk), .rst(rst), .set_vec(set_vec),
        .clr_en(can_go), .clr_idx(win_vec), .pend(pend)
    );

    irq_arbiter #(.NVEC(NVEC)) u_arb (
        .pend(pend), .prio_cfg(prio_cfg), .cur_lvl(exec_lvl), .gmask(gmask),
        .pick(pick), .win_vec(win_vec)
    );

    irq_level_stack #(.DEPTH(DEPTH)) u_stk (
        .clk(clk), .rst(rst),
        .push(can_go && !pick.rst_win),
        .pop(iret && !stk_empty),
        .clear(can_go && pick.rst_win),
        .push_lvl(exec_lvl),
        .top_lvl(stk_top), .empty(stk_empty), .full(stk_full)
    );

    assign can_go = pick.hit && !busy && !iret && (pick.rst_win || !stk_full);

    always_ff @(posedge clk) begin
        if (rst) begin
            take     <= 1'b0;
            busy     <= 1'b0;
            vec_idx  <= '0;
            exec_lvl <= LVL_OFF;
        end else begin
            take <= 1'b0;
            if (can_go) begin
                take     <= 1'b1;
                busy     <= 1'b1;
                vec_idx  <= win_vec;
                exec_lvl <= pick.lvl;
            end else begin
                if (busy && ack) begin
                    busy <= 1'b0;
                end
                if (iret && !stk_empty) begin
                    exec_lvl <= stk_top;
                end
            end
        end
    end

    // R8: the take pulse lasts one cycle
    a_r8_take_pulse: assert property (@(posedge clk) disable iff (rst)
        take |=> !take);
    // R9: no new take while a grant waits for its acknowledge
    a_r9_wait_ack: assert property (@(posedge clk) disable iff (rst)
        (busy && !ack) |=> !take);
    // R4: a maskable grant raises the level strictly
    a_r4_strict_rise: assert property (@(posedge clk) disable iff (rst)
        (take && vec_idx >= VW'(2)) |-> (exec_lvl > $past(exec_lvl)));
    // R7: no maskable grant follows a cycle with the mask set
    a_r7_mask_blocks: assert property (@(posedge clk) disable iff (rst)
        (take && vec_idx >= VW'(2)) |-> !$past(gmask));
    // R6: non-maskable grants run at the top level
    a_r6_nmi_top: assert property (@(posedge clk) disable iff (rst)
        (take && vec_idx < VW'(2)) |-> (exec_lvl == LVL_TOP));

endmodule

// File: tb/test_nest_irq_ctrl.sv
module test_nest_irq_ctrl;
    localparam int CLK_P = 10;
    localparam int NVEC  = 32;
    localparam int NPINS = 27;
    localparam int NGRP  = 6;
    localparam int NPER  = NVEC - 3 - NGRP;

    logic                clk = 1'b0;
    logic                rst;
    logic [NPINS-1:0]    ext_pin;
    logic                tli_pin, trap_req, swrst_req;
    logic [NPER-1:0]     periph_req;
    logic [2*NVEC-5:0]   prio_cfg;
    logic                gmask, ack, iret;
    logic                take;
    logic [4:0]          vec_idx;
    logic [1:0]          exec_lvl;

    int n_total = 0;
    int n_fail  = 0;

    always #(CLK_P/2) clk = ~clk;

    nest_irq_ctrl i_nest_irq_ctrl (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .tli_pin(tli_pin),
        .periph_req(periph_req), .trap_req(trap_req), .swrst_req(swrst_req),
        .prio_cfg(prio_cfg), .gmask(gmask), .ack(ack), .iret(iret),
        .take(take), .vec_idx(vec_idx), .exec_lvl(exec_lvl)
    );

    typedef struct packed {
        logic [31:0] raise;
        logic [7:0]  va;
        logic [1:0]  la;
        logic [7:0]  vb;
        logic [1:0]  lb;
        logic        hit;
        logic [7:0]  vec;
        logic [1:0]  lvl;
    } case_t;

    // va/vb = 0 means no level override; all maskable vectors start at level 1
    localparam case_t CASES [9] = '{
        '{32'h0000_1200, 8'd0,  2'd0, 8'd0,  2'd0, 1'b1, 8'd9,  2'd1},
        '{32'h0000_1200, 8'd12, 2'd3, 8'd0,  2'd0, 1'b1, 8'd12, 2'd3},
        '{32'h0010_0004, 8'd20, 2'd2, 8'd0,  2'd0, 1'b1, 8'd20, 2'd2},
        '{32'h8000_0020, 8'd5,  2'd0, 8'd0,  2'd0, 1'b1, 8'd31, 2'd1},
        '{32'h0000_0202, 8'd9,  2'd3, 8'd0,  2'd0, 1'b1, 8'd1,  2'd3},
        '{32'h0000_0203, 8'd0,  2'd0, 8'd0,  2'd0, 1'b1, 8'd0,  2'd3},
        '{32'h0000_0018, 8'd3,  2'd2, 8'd4,  2'd2, 1'b1, 8'd3,  2'd2},
        '{32'h4000_0000, 8'd30, 2'd0, 8'd0,  2'd0, 1'b0, 8'd0,  2'd0},
        '{32'h0000_0E00, 8'd10, 2'd2, 8'd11, 2'd2, 1'b1, 8'd10, 2'd2}
    };

    task automatic check(input string req, input int act, input int exp);
        n_total++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_lvl(input int v, input logic [1:0] l);
        prio_cfg[2*(v-2) +: 2] = l;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ext_pin = '0; tli_pin = 0; trap_req = 0; swrst_req = 0; periph_req = '0;
        gmask = 0; ack = 0; iret = 0;
        for (int v = 2; v < NVEC; v++) set_lvl(v, 2'd1);
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic drive_vec(input int v, input logic val);
        if (v == 0) swrst_req = val;
        else if (v == 1) trap_req = val;
        else if (v == 2) tli_pin = val;
        else if (v < 3 + NGRP) ext_pin[(v-3)*5] = val;
        else periph_req[v-3-NGRP] = val;
    endtask

    // raise at a falling edge, drop one cycle later, return after the grant edge
    task automatic pulse(input logic [31:0] m);
        for (int v = 0; v < NVEC; v++) if (m[v]) drive_vec(v, 1'b1);
        @(negedge clk);
        for (int v = 0; v < NVEC; v++) if (m[v]) drive_vec(v, 1'b0);
        @(negedge clk);
    endtask

    task automatic do_ack();
        ack = 1'b1; @(negedge clk); ack = 1'b0;
    endtask

    task automatic do_iret();
        iret = 1'b1; @(negedge clk); iret = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_fail++; n_total++;
        $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        rst = 1'b1;
        // table of arbitration cases (R3, R5, R6)
        for (int i = 0; i < 9; i++) begin
            do_reset();
            if (CASES[i].va != 0) set_lvl(int'(CASES[i].va), CASES[i].la);
            if (CASES[i].vb != 0) set_lvl(int'(CASES[i].vb), CASES[i].lb);
            pulse(CASES[i].raise);
            check("R5 table take", int'(take), int'(CASES[i].hit));
            check("R5 table vec", int'(vec_idx), int'(CASES[i].vec));
            check("R3 table lvl", int'(exec_lvl), int'(CASES[i].lvl));
        end

        // R12: reset state; a pin held high through reset is no edge
        @(negedge clk); rst = 1'b1; ext_pin[0] = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R12 take", int'(take), 0);
        check("R12 vec", int'(vec_idx), 0);
        check("R12 lvl", int'(exec_lvl), 0);
        ext_pin[0] = 1'b0;

        // R2 / R1: two pins of group 0 give one grant, held pin does not relatch
        do_reset();
        ext_pin[0] = 1; ext_pin[3] = 1;
        @(negedge clk); ext_pin[0] = 0;
        @(negedge clk);
        check("R2 group take", int'(take), 1);
        check("R2 group vec", int'(vec_idx), 3);
        @(negedge clk);
        check("R8 one cycle", int'(take), 0);
        check("R8 vec held", int'(vec_idx), 3);
        do_ack(); do_iret();
        repeat (3) @(negedge clk);
        check("R1 no relatch", int'(take), 0);
        ext_pin[3] = 0;
        ext_pin[5] = 1; @(negedge clk); ext_pin[5] = 0; @(negedge clk);
        check("R2 pin5 vec", int'(vec_idx), 4);
        do_ack(); do_iret();
        ext_pin[26] = 1; @(negedge clk); ext_pin[26] = 0; @(negedge clk);
        check("R2 pin26 vec", int'(vec_idx), 8);
        do_ack(); do_iret();
        pulse(32'h0000_0200);
        check("R2 periph0 vec", int'(vec_idx), 9);

        // R4 / R10 nesting
        do_reset();
        set_lvl(9, 2'd2); set_lvl(10, 2'd2); set_lvl(11, 2'd3);
        pulse(32'h0000_0200);
        check("R4 first take", int'(take), 1);
        check("R4 first lvl", int'(exec_lvl), 2);
        do_ack();
        pulse(32'h0000_0400);
        check("R4 equal level held", int'(take), 0);
        @(negedge clk);
        check("R4 equal level held2", int'(take), 0);
        pulse(32'h0000_0800);
        check("R4 higher vec", int'(vec_idx), 11);
        check("R4 higher lvl", int'(exec_lvl), 3);
        do_ack();
        do_iret();
        check("R10 restore 2", int'(exec_lvl), 2);
        check("R10 still held", int'(take), 0);
        do_iret();
        check("R10 restore 0", int'(exec_lvl), 0);
        check("R10 no grant on iret", int'(take), 0);
        @(negedge clk);
        check("R4 waiting vec", int'(vec_idx), 10);
        check("R4 waiting take", int'(take), 1);

        // R7 / R6 mask
        do_reset();
        gmask = 1'b1;
        pulse(32'h0000_0200);
        check("R7 masked", int'(take), 0);
        pulse(32'h0000_0002);
        check("R6 trap vec", int'(vec_idx), 1);
        check("R6 trap lvl", int'(exec_lvl), 3);
        do_ack();
        gmask = 1'b0;
        do_iret();
        check("R10 back to 0", int'(exec_lvl), 0);
        @(negedge clk);
        check("R7 kept pending", int'(vec_idx), 9);
        check("R7 kept take", int'(take), 1);

        // R9 ack hold
        do_reset();
        set_lvl(12, 2'd3);
        pulse(32'h0000_0200);
        check("R9 first take", int'(take), 1);
        pulse(32'h0000_1000);
        check("R9 held", int'(take), 0);
        @(negedge clk);
        check("R9 held2", int'(take), 0);
        do_ack();
        @(negedge clk);
        check("R9 after ack vec", int'(vec_idx), 12);
        check("R9 after ack take", int'(take), 1);

        // R10 iret on empty stack
        do_reset();
        do_iret();
        check("R10 empty iret", int'(exec_lvl), 0);

        // R11 stack full
        do_reset();
        for (int k = 0; k < 4; k++) begin
            pulse(32'h0000_0002);
            check("R11 nest trap", int'(take), 1);
            do_ack();
        end
        pulse(32'h0000_0002);
        check("R11 full holds trap", int'(take), 0);
        pulse(32'h0000_0001);
        check("R11 reset vec", int'(vec_idx), 0);
        check("R11 reset take", int'(take), 1);
        do_ack();
        @(negedge clk);
        check("R11 trap after room", int'(vec_idx), 1);
        check("R11 trap take", int'(take), 1);
        do_ack();
        do_iret();
        check("R11 pop to 3", int'(exec_lvl), 3);
        do_iret();
        check("R11 stack emptied", int'(exec_lvl), 3);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule